// File: doc/BRIEF.md
# I2C SCL Divider Encoder and Clock Generator

This block converts a divide ratio (peripheral clock frequency over wanted I2C bus clock frequency) into the three timing fields of an I2C master's clock-timing word: a power-of-two prescaler exponent, an SCL low count and an SCL high count. Ratios of 16 or more are brought into range by halving them one step per clock. Every halving bumps the exponent, and any 1 bit lost on the way forces a final round-up, so the bus never runs faster than requested. The normalised ratio is then split into a low count and a slightly larger high count. The result is packed over a fixed base word whose upper hold and setup bits stay constant.

Software or a sequencer pulses `start_i` with the ratio and the wanted bus rate in kHz, and waits for `done_o`. The packed word and a set of function-control bits then stay valid until the next computation. When the bus rate is above the fast-mode limit, the function-control bits switch on high-speed mode and the one-cycle SDA drive options. A built-in generator turns the stored fields into an SCL waveform: the peripheral clock is divided by two to the power of the exponent, and the result is counted through the low and high phases.

Top module: `scl_divider_top`

## Requirements
- R1: A ratio of 0 or 1 is treated as 2, giving exponent 0, low count 0 and high count 0.
- R2: While the working ratio is 16 or more it is halved once per clock and the exponent increments. `busy_o` is high from the cycle after the accepted start until the done cycle. `done_o` appears exactly (halvings + 2) clock cycles after the edge that sampled `start_i`, counting that edge's cycle as the first.
- R3: If any 1 bit was shifted out during halving, the normalised ratio is incremented by one (so 31 becomes 16 with exponent 1).
- R4: low = normalised/2 − 1 (integer division) and high = normalised − low − 2.
- R5: `timing_word_o` = 0x77700300 OR (high << 16) OR (low << 12) OR exponent, with the exponent in bits 3:0.
- R6: `done_o` is a single-cycle pulse. Outputs hold their values after it.
- R7: A `start_i` pulse while `busy_o` is high is ignored, and the running computation finishes with its own ratio.
- R8: `func_ctrl_o` bits 6 (high-speed), 7 (master SDA one-cycle drive) and 8 (SDA one-cycle drive) are all 1 when `bus_khz_i` sampled at start is greater than 400. Otherwise they are 0. Bits 5:0 are always 0.
- R9: While the generator is disabled, `scl_o` is 1. After the edge that samples `gen_en_i` high, `scl_o` goes low, and it returns to 1 after the edge that samples `gen_en_i` low.
- R10: With the generator running, each SCL low phase lasts (low+1)·2^exponent clocks and each high phase lasts (high+1)·2^exponent clocks.
- R11: After reset `busy_o` and `done_o` are 0, `timing_word_o` is 0x77700300, `func_ctrl_o` is 0 and `scl_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start a computation (taken only when idle) |
| ratio_i | input | RATIO_W | Peripheral-to-bus clock ratio |
| bus_khz_i | input | KHZ_W | Wanted bus rate in kHz, selects high-speed settings |
| gen_en_i | input | 1 | Enable the SCL generator |
| busy_o | output | 1 | Normalisation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| timing_word_o | output | 32 | Packed clock-timing word |
| func_ctrl_o | output | 9 | Function-control bits for speed mode |
| scl_o | output | 1 | Generated SCL waveform |

## Verification
The hardest cases to reach are the longest normalisation chains and the sticky round-up that pushes the normalised ratio back to exactly 16. The stimulus uses all-ones ratios (31, 65535), which shed a 1 on every halving and need the full shift count. The second hard case is a start pulse that lands while a computation is running. The bench times a second start inside a long halving chain, then checks that both the latency and the fields belong to the first ratio. SCL phase lengths are measured in clocks for exponents 0 and 3, including the clamped minimum ratio.

// File: rtl/scl_div_pkg.sv
// Package: shared constants and types for the SCL divider block.
// Assumes phase counts never exceed 7, which the normalisation guarantees.
package scl_div_pkg;
    localparam int unsigned CNT_W       = 4;
    localparam int unsigned NORM_W      = 5;
    localparam int unsigned NORM_LIMIT  = 16;
    localparam int unsigned WORD_W      = 32;
    localparam logic [WORD_W-1:0] TIMING_BASE = 32'h7770_0300;
    localparam int unsigned HIGH_LSB    = 16;
    localparam int unsigned LOW_LSB     = 12;
    localparam int unsigned FC_W        = 9;
    localparam int unsigned FC_HS_BIT   = 6;
    localparam int unsigned FC_MDRV_BIT = 7;
    localparam int unsigned FC_SDRV_BIT = 8;

    typedef struct packed {
        logic [CNT_W-1:0] high;
        logic [CNT_W-1:0] low;
    } phase_cnt_t;
endpackage

// File: rtl/scl_phase_split.sv
// Module: scl_phase_split
// Splits a working ratio below 16 plus a round-up flag into SCL low and
// high counts. Purely combinational. Assumes the ratio is 2..15 and that
// the round-up adds at most 1, so the normalised value is 2..16.
module scl_phase_split
    import scl_div_pkg::*;
(
    input  logic [3:0]        work_i,
    input  logic              sticky_i,
    output logic [NORM_W-1:0] norm_o,
    output phase_cnt_t        cnt_o
);
    logic [NORM_W-1:0] low_w;
    logic [NORM_W-1:0] high_w;

    // Round up, then derive the asymmetric low/high split.
    always_comb begin
        norm_o  = {1'b0, work_i} + NORM_W'(sticky_i);
        low_w   = (norm_o >> 1) - NORM_W'(1);
        high_w  = norm_o - low_w - NORM_W'(2);
        cnt_o.low  = low_w[CNT_W-1:0];
        cnt_o.high = high_w[CNT_W-1:0];
    end
endmodule

// File: rtl/scl_ratio_norm.sv
// Module: scl_ratio_norm
// Sequential normaliser: clamps the ratio to at least 2, halves it once
// per clock while it is 16 or more, counts the halvings as the exponent
// and records any dropped 1 bits. It registers the split counts on the
// cycle that finds the ratio below 16. Starts are ignored while busy.
module scl_ratio_norm
    import scl_div_pkg::*;
#(
    parameter int unsigned RATIO_W = 16,
    parameter int unsigned EXP_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [RATIO_W-1:0] ratio_i,
    input  logic               fast_i,
    output logic               busy_o,
    output logic               done_o,
    output logic [EXP_W-1:0]   exp_o,
    output phase_cnt_t         cnt_o,
    output logic               fast_o
);
    logic               busy_q;
    logic               done_q;
    logic [RATIO_W-1:0] work_q;
    logic               sticky_q;
    logic [EXP_W-1:0]   wexp_q;
    logic               fast_w_q;
    logic [EXP_W-1:0]   exp_q;
    phase_cnt_t         cnt_q;
    logic               fast_q;
    logic               need_shift;
    logic [NORM_W-1:0]  norm_w;
    phase_cnt_t         split_w;

    assign need_shift = (work_q >= RATIO_W'(NORM_LIMIT));

    scl_phase_split u_split (
        .work_i   (work_q[3:0]),
        .sticky_i (sticky_q),
        .norm_o   (norm_w),
        .cnt_o    (split_w)
    );

    // Control and datapath of the halving loop plus result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q   <= 1'b0;
            done_q   <= 1'b0;
            work_q   <= '0;
            sticky_q <= 1'b0;
            wexp_q   <= '0;
            fast_w_q <= 1'b0;
            exp_q    <= '0;
            cnt_q    <= '0;
            fast_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q) begin
                if (start_i) begin
                    busy_q   <= 1'b1;
                    work_q   <= (ratio_i < RATIO_W'(2)) ? RATIO_W'(2) : ratio_i;
                    sticky_q <= 1'b0;
                    wexp_q   <= '0;
                    fast_w_q <= fast_i;
                end
            end else if (need_shift) begin
                work_q   <= work_q >> 1;
                sticky_q <= sticky_q | work_q[0];
                wexp_q   <= wexp_q + EXP_W'(1);
            end else begin
                busy_q <= 1'b0;
                done_q <= 1'b1;
                exp_q  <= wexp_q;
                cnt_q  <= split_w;
                fast_q <= fast_w_q;
            end
        end
    end

    assign busy_o = busy_q;
    assign done_o = done_q;
    assign exp_o  = exp_q;
    assign cnt_o  = cnt_q;
    assign fast_o = fast_q;

    // R6: completion is a single-cycle pulse.
    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
    // R6: completion and busy never overlap.
    a_r6_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> !busy_q);
    // R1: the working ratio never drops below the clamp value.
    a_r1_min_two: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (work_q >= RATIO_W'(2)));
    // R2: each busy cycle with a large ratio halves it and stays busy.
    a_r2_halving: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && need_shift) |=> (busy_q && work_q == ($past(work_q) >> 1)));
    // R4: captured counts add up to the normalised ratio minus two.
    a_r4_split_sum: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (int'(cnt_q.low) + int'(cnt_q.high) + 2 == int'($past(norm_w))));
    // R4: low count is half the normalised ratio minus one.
    a_r4_low_half: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (int'(cnt_q.low) == int'($past(norm_w)) / 2 - 1));
endmodule

// File: rtl/scl_word_pack.sv
// Module: scl_word_pack
// Packs exponent and phase counts onto the fixed timing base and forms the
// speed-mode function-control bits. Combinational; assumes the counts fit
// their fields.
module scl_word_pack
    import scl_div_pkg::*;
#(
    parameter int unsigned EXP_W = 4
) (
    input  logic [EXP_W-1:0]  exp_i,
    input  phase_cnt_t        cnt_i,
    input  logic              fast_i,
    output logic [WORD_W-1:0] word_o,
    output logic [FC_W-1:0]   func_o
);
    // Overlay the fields on the base word.
    always_comb begin
        word_o = TIMING_BASE
               | (WORD_W'(cnt_i.high) << HIGH_LSB)
               | (WORD_W'(cnt_i.low)  << LOW_LSB)
               | WORD_W'(exp_i);
    end

    // Speed-mode bits follow the latched fast-rate flag.
    always_comb begin
        func_o              = '0;
        func_o[FC_HS_BIT]   = fast_i;
        func_o[FC_MDRV_BIT] = fast_i;
        func_o[FC_SDRV_BIT] = fast_i;
    end
endmodule

// File: rtl/scl_wave_gen.sv
// Module: scl_wave_gen
// Generates SCL from the stored fields: a prescaler ticks every
// 2^exp clocks, and a phase counter toggles SCL after low+1 or high+1
// ticks. SCL idles high; counting starts one cycle after enable is seen.
module scl_wave_gen
    import scl_div_pkg::*;
#(
    parameter int unsigned EXP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [EXP_W-1:0] exp_i,
    input  phase_cnt_t       cnt_i,
    output logic             scl_o
);
    localparam int unsigned PRESC_W = (1 << EXP_W) - 1;

    logic               active_q;
    logic               scl_q;
    logic [PRESC_W-1:0] presc_q;
    logic [CNT_W-1:0]   phase_q;
    logic [PRESC_W-1:0] mask_w;
    logic               tick;
    logic [CNT_W-1:0]   limit_w;

    // Prescaler terminal value: exp_i ones.
    always_comb begin
        mask_w = '0;
        for (int i = 0; i < int'(PRESC_W); i++) begin
            if (i < int'(exp_i)) mask_w[i] = 1'b1;
        end
    end

    assign tick    = (presc_q >= mask_w);
    assign limit_w = scl_q ? cnt_i.high : cnt_i.low;

    // Register the enable so counting starts a cycle after it is seen.
    always_ff @(posedge clk) begin
        if (!rst_n) active_q <= 1'b0;
        else        active_q <= en_i;
    end

    // Prescaler and phase counter driving the SCL level.
    always_ff @(posedge clk) begin
        if (!rst_n || !active_q) begin
            presc_q <= '0;
            phase_q <= '0;
            scl_q   <= 1'b0;
        end else if (tick) begin
            presc_q <= '0;
            if (phase_q >= limit_w) begin
                phase_q <= '0;
                scl_q   <= ~scl_q;
            end else begin
                phase_q <= phase_q + CNT_W'(1);
            end
        end else begin
            presc_q <= presc_q + PRESC_W'(1);
        end
    end

    assign scl_o = active_q ? scl_q : 1'b1;

    // R10: the running level only changes on a prescaler tick.
    a_r10_toggle_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && $past(active_q) && !$stable(scl_q)) |-> $past(tick));
    // R9: a fresh enable always begins with the low phase.
    a_r9_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && !$past(active_q)) |-> !scl_o);
endmodule

// File: rtl/scl_divider_top.sv
// Module: scl_divider_top
// Top of the SCL divider: normaliser, phase split, word packing and the
// SCL generator. Assumes ratio and bus rate stay stable only in the
// cycle start_i is sampled; the results are held until the next run.
module scl_divider_top
    import scl_div_pkg::*;
#(
    parameter int unsigned RATIO_W  = 16,
    parameter int unsigned KHZ_W    = 16,
    parameter int unsigned FAST_KHZ = 400
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [RATIO_W-1:0] ratio_i,
    input  logic [KHZ_W-1:0]   bus_khz_i,
    input  logic               gen_en_i,
    output logic               busy_o,
    output logic               done_o,
    output logic [31:0]        timing_word_o,
    output logic [8:0]         func_ctrl_o,
    output logic               scl_o
);
    localparam int unsigned EXP_W = $clog2(RATIO_W);

    logic             fast_req;
    logic             fast_lat;
    logic [EXP_W-1:0] exp_w;
    phase_cnt_t       cnt_w;

    assign fast_req = (bus_khz_i > KHZ_W'(FAST_KHZ));

    scl_ratio_norm #(.RATIO_W(RATIO_W), .EXP_W(EXP_W)) u_norm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .ratio_i (ratio_i),
        .fast_i  (fast_req),
        .busy_o  (busy_o),
        .done_o  (done_o),
        .exp_o   (exp_w),
        .cnt_o   (cnt_w),
        .fast_o  (fast_lat)
    );

    scl_word_pack #(.EXP_W(EXP_W)) u_pack (
        .exp_i  (exp_w),
        .cnt_i  (cnt_w),
        .fast_i (fast_lat),
        .word_o (timing_word_o),
        .func_o (func_ctrl_o)
    );

    scl_wave_gen #(.EXP_W(EXP_W)) u_gen (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (gen_en_i),
        .exp_i (exp_w),
        .cnt_i (cnt_w),
        .scl_o (scl_o)
    );
endmodule

// File: tb/scl_divider_top_tb.sv
module scl_divider_top_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] ratio_i = '0;
    logic [15:0] bus_khz_i = '0;
    logic        gen_en_i = 1'b0;
    logic        busy_o, done_o, scl_o;
    logic [31:0] timing_word_o;
    logic [8:0]  func_ctrl_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    scl_divider_top u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .ratio_i(ratio_i),
        .bus_khz_i(bus_khz_i), .gen_en_i(gen_en_i), .busy_o(busy_o),
        .done_o(done_o), .timing_word_o(timing_word_o),
        .func_ctrl_o(func_ctrl_o), .scl_o(scl_o)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Behavioural reference for the encoding.
    task automatic model(input int ratio, output int e, output int lo, output int hi, output int shifts);
        int r = (ratio < 2) ? 2 : ratio;
        int s = 0;
        e = 0;
        while (r >= 16) begin
            s = s | (r & 1);
            r = r >> 1;
            e++;
        end
        shifts = e;
        r = r + s;
        lo = r / 2 - 1;
        hi = r - lo - 2;
    endtask

    function automatic int pack(input int e, input int lo, input int hi);
        return 32'h7770_0300 | (hi << 16) | (lo << 12) | e;
    endfunction

    int last_e, last_lo, last_hi;

    // Run one computation; optionally inject a second start while busy.
    task automatic run_ratio(input int ratio, input int khz, input bit inject, input string req);
        int e, lo, hi, sh, lat, exp_fc;
        model(ratio, e, lo, hi, sh);
        exp_fc = (khz > 400) ? 9'h1C0 : 9'h000;
        @(negedge clk);
        ratio_i = 16'(ratio); bus_khz_i = 16'(khz); start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        lat = 1;
        while (!done_o) begin
            // R2: busy is high on every cycle before done
            check(busy_o == 1'b1, "R2 busy during halving", busy_o, 1);
            if (inject && lat == 2) begin
                ratio_i = 16'd3; bus_khz_i = 16'd0; start_i = 1'b1;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
            lat++;
        end
        start_i = 1'b0;
        check(lat == sh + 2, {req, " R2 latency"}, lat, sh + 2);
        check(busy_o == 1'b0, "R6 busy low at done", busy_o, 0);
        check(timing_word_o == 32'(pack(e, lo, hi)), {req, " R5 word"}, timing_word_o, pack(e, lo, hi));
        check(func_ctrl_o == 9'(exp_fc), {req, " R8 func"}, func_ctrl_o, exp_fc);
        @(negedge clk);
        check(done_o == 1'b0, "R6 done single pulse", done_o, 0);
        check(timing_word_o == 32'(pack(e, lo, hi)), "R6 word held", timing_word_o, pack(e, lo, hi));
        last_e = e; last_lo = lo; last_hi = hi;
    endtask

    // Measure SCL phases with the stored fields.
    task automatic run_gen(input string req);
        int nl, nh, nl2;
        int exp_l = (last_lo + 1) << last_e;
        int exp_h = (last_hi + 1) << last_e;
        @(negedge clk);
        check(scl_o == 1'b1, "R9 idle high", scl_o, 1);
        gen_en_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(scl_o == 1'b0, "R9 low after enable", scl_o, 0);
        nl = 1;
        while (scl_o == 1'b0) begin @(negedge clk); nl++; end
        nh = 1;
        while (scl_o == 1'b1) begin @(negedge clk); nh++; end
        nl2 = 1;
        while (scl_o == 1'b0) begin @(negedge clk); nl2++; end
        check(nl - 1 == exp_l, {req, " R10 low phase"}, nl - 1, exp_l);
        check(nh - 1 == exp_h, {req, " R10 high phase"}, nh - 1, exp_h);
        check(nl2 - 1 == exp_l, {req, " R10 second low"}, nl2 - 1, exp_l);
        gen_en_i = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(scl_o == 1'b1, "R9 high after disable", scl_o, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset values
        check(busy_o == 1'b0, "R11 busy", busy_o, 0);
        check(done_o == 1'b0, "R11 done", done_o, 0);
        check(timing_word_o == 32'h7770_0300, "R11 word", timing_word_o, 32'h7770_0300);
        check(func_ctrl_o == 9'h0, "R11 func", func_ctrl_o, 0);
        check(scl_o == 1'b1, "R11 scl", scl_o, 1);
        rst_n = 1'b1;

        run_ratio(5, 100, 0, "R4 ratio5");
        run_gen("R10 ratio5");
        run_ratio(0, 100, 0, "R1 ratio0");
        run_ratio(1, 100, 0, "R1 ratio1");
        run_gen("R1 ratio1");
        run_ratio(15, 400, 0, "R4 ratio15");
        run_ratio(16, 1000, 0, "R2 ratio16");
        run_ratio(31, 1000, 0, "R3 ratio31");
        run_ratio(100, 401, 0, "R3 ratio100");
        run_gen("R10 ratio100");
        run_ratio(65535, 100, 0, "R2 ratio65535");
        // R7: a second start during busy must not alter the result
        run_ratio(1000, 1000, 1, "R7 ignore start");
        @(negedge clk);
        check(busy_o == 1'b0, "R7 no second run", busy_o, 0);

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule